// File: doc/BRIEF.md
# Signed Arithmetic Unit with Error Flag

This block is a sequential two's-complement arithmetic unit. A requester places an opcode and two signed operands on its inputs and raises a request line. The unit answers with a result word, a second word that carries the division remainder, a done flag and an error flag. The error flag covers three cases: a sum, difference or product that does not fit the signed word, a zero divisor, and the single quotient that cannot be represented (most negative value divided by minus one).

Add, subtract, multiply and no-op finish in the cycle that accepts the request. Divide uses an iterative restoring divider that works on operand magnitudes and then applies the sign. The quotient truncates toward zero, and the remainder is always reported as a non-negative magnitude. The interface uses a four-phase handshake. The requester holds the request and the operands steady until done rises. The unit then holds done and the result for as long as the request stays high. Back-pressure therefore comes entirely from the requester: the result is not lost until the requester drops the request.

Top module: `sarith_unit`

## Requirements
- R1: Opcode encoding on `op_code`: 0 no-op, 1 add, 2 subtract, 3 multiply, 4 divide. Codes 0, 5, 6 and 7 complete with result 0, remainder 0 and no error.
- R2: Add and subtract return the exact W-bit signed sum or difference when it lies within the signed range, including exactly at either end. A true result outside that range sets the error flag.
- R3: Multiply returns the exact product when it lies within the W-bit signed range. Otherwise the error flag is set.
- R4: Divide returns the quotient truncated toward zero, with the sign given by the operand signs. When the divisor magnitude exceeds the dividend magnitude, the quotient is 0.
- R5: For divide without error, `remainder` holds the magnitude of the true remainder, independent of the operand signs. For all other opcodes it is 0.
- R6: A zero divisor, or the most negative dividend divided by -1, sets the error flag.
- R7: Whenever the error flag is high, done is high and both `result` and `remainder` are 0.
- R8: An operation starts only on a low-to-high transition of `req`. While `req` stays high after done, done remains high and `result`/`remainder` stay unchanged even if the operands or the opcode change.
- R9: After `req` is sampled low while done is high, done and the error flag are low from the next rising edge. The result words keep their values.
- R10: Active-low reset clears done, the error flag, `result` and `remainder`, and abandons any operation in progress.
- R11: Counting the rising edge that first samples `req` high as edge 1, done is visible after edge 1 for no-op, add, subtract, multiply and erroneous divide, and after edge W+3 for a regular divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| op_code | input | 3 | Operation select |
| opa | input | W | Signed first operand (dividend, minuend) |
| opb | input | W | Signed second operand (divisor, subtrahend) |
| req | input | 1 | Calculate request, held until done |
| result | output | W | Signed result or quotient |
| remainder | output | W | Remainder magnitude for divide, else 0 |
| done | output | 1 | Result valid; held until req drops |
| err | output | 1 | Overflow or division error, valid with done |

## Verification
Two events are meant to share a cycle: detecting an error and completing the operation. The error flag must appear on the very sample where done first rises, together with zeroed result words, and must never show up before or after that window. This coincidence is provoked with operands at the edges of the signed range, with a zero divisor, and with the one quotient that does not fit. These operands also move a divide off the iterative path and onto the single-edge path, so the same sample also judges the edge count to done. A full sweep of a 5-bit instance over every operand pair and opcode drives every overflow boundary against an arithmetic model, and 32-bit directed cases cover the wide extremes.

// File: rtl/sarith_pkg.sv
package sarith_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_MUL = 3'd3,
    OP_DIV = 3'd4
  } sarith_op_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_DIVWAIT,
    CT_HOLD
  } sarith_ctl_e;
endpackage

// File: rtl/sarith_addsub.sv
module sarith_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0] ext_a, ext_b, s;

  always_comb begin
    ext_a = {a[W-1], a};
    ext_b = sub ? -{b[W-1], b} : {b[W-1], b};
    s     = ext_a + ext_b;
    sum   = s[W-1:0];
    ovf   = s[W] ^ s[W-1];
  end
endmodule

// File: rtl/sarith_mul.sv
module sarith_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod,
  output logic         ovf
);
  localparam int PW = 2 * W;
  logic [PW-1:0] p;
  logic [W:0]    upper;

  always_comb begin
    p     = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    upper = p[PW-1:W-1];
    prod  = p[W-1:0];
    ovf   = !((&upper) || (~|upper));
  end
endmodule

// File: rtl/sarith_div.sv
module sarith_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rmd,
  output logic         fin
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy, fixing, neg_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  q_sh, r_acc, dvs;
  logic [W:0]    r_sh, diff;
  logic          ge;

  always_comb begin
    r_sh = {r_acc, q_sh[W-1]};
    diff = r_sh - {1'b0, dvs};
    ge   = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fixing <= 1'b0;
      neg_q  <= 1'b0;
      cnt    <= '0;
      q_sh   <= '0;
      r_acc  <= '0;
      dvs    <= '0;
      quo    <= '0;
      rmd    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        fixing <= 1'b0;
        cnt    <= '0;
        r_acc  <= '0;
        q_sh   <= dividend[W-1] ? -dividend : dividend;
        dvs    <= divisor[W-1] ? -divisor : divisor;
        neg_q  <= dividend[W-1] ^ divisor[W-1];
      end else if (busy) begin
        r_acc <= ge ? diff[W-1:0] : r_sh[W-1:0];
        q_sh  <= {q_sh[W-2:0], ge};
        cnt   <= cnt + CW'(1);
        if (cnt == LAST) begin
          busy   <= 1'b0;
          fixing <= 1'b1;
        end
      end else if (fixing) begin
        fixing <= 1'b0;
        fin    <= 1'b1;
        quo    <= neg_q ? -q_sh : q_sh;
        rmd    <= r_acc;
      end
    end
  end
endmodule

// File: rtl/sarith_unit.sv
module sarith_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         req,
  output logic [W-1:0] result,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         err
);
  import sarith_pkg::*;

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  sarith_ctl_e  ctl;
  logic         req_q, start, div_special, div_go;
  logic [W-1:0] as_sum, mul_prod, d_quo, d_rmd;
  logic         as_ovf, mul_ovf, d_fin;

  sarith_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb), .sub(op_code == OP_SUB), .sum(as_sum), .ovf(as_ovf)
  );

  sarith_mul #(.W(W)) u_mul (
    .a(opa), .b(opb), .prod(mul_prod), .ovf(mul_ovf)
  );

  always_comb begin
    start       = (ctl == CT_IDLE) && req && !req_q;
    div_special = (opb == '0) || ((opa == MINV) && (opb == '1));
    div_go      = start && (op_code == OP_DIV) && !div_special;
  end

  sarith_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go),
    .dividend(opa), .divisor(opb),
    .quo(d_quo), .rmd(d_rmd), .fin(d_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl       <= CT_IDLE;
      req_q     <= 1'b0;
      result    <= '0;
      remainder <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      req_q <= req;
      case (ctl)
        CT_IDLE: begin
          if (start) begin
            remainder <= '0;
            case (op_code)
              OP_ADD, OP_SUB: begin
                result <= as_ovf ? '0 : as_sum;
                err    <= as_ovf;
                done   <= 1'b1;
                ctl    <= CT_HOLD;
              end
              OP_MUL: begin
                result <= mul_ovf ? '0 : mul_prod;
                err    <= mul_ovf;
                done   <= 1'b1;
                ctl    <= CT_HOLD;
              end
              OP_DIV: begin
                if (div_special) begin
                  result <= '0;
                  err    <= 1'b1;
                  done   <= 1'b1;
                  ctl    <= CT_HOLD;
                end else begin
                  ctl <= CT_DIVWAIT;
                end
              end
              default: begin
                result <= '0;
                err    <= 1'b0;
                done   <= 1'b1;
                ctl    <= CT_HOLD;
              end
            endcase
          end
        end
        CT_DIVWAIT: begin
          if (d_fin) begin
            result    <= d_quo;
            remainder <= d_rmd;
            err       <= 1'b0;
            done      <= 1'b1;
            ctl       <= CT_HOLD;
          end
        end
        CT_HOLD: begin
          if (!req) begin
            done <= 1'b0;
            err  <= 1'b0;
            ctl  <= CT_IDLE;
          end
        end
        default: ctl <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sarith_unit_chk.sv
module sarith_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic [W-1:0] result,
  input logic [W-1:0] remainder,
  input logic         done,
  input logic         err
);
  // R8
  done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> done);

  // R8
  result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> ($stable(result) && $stable(remainder)));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> (!done && !err));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R7
  err_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (result == '0 && remainder == '0));

  // R5
  rem_magnitude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !remainder[W-1]);
endmodule

bind sarith_unit sarith_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .result(result),
  .remainder(remainder), .done(done), .err(err)
);

// File: tb/sarith_unit_tb_top.sv
module sarith_unit_tb_top;
  localparam int WL = 32;
  localparam int WS = 5;
  localparam longint MAXV = 2147483647;
  localparam longint MINV = -longint'(2147483647) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]    op_l, op_s;
  logic [WL-1:0] a_l, b_l, res_l, rem_l;
  logic [WS-1:0] a_s, b_s, res_s, rem_s;
  logic          req_l, req_s, done_l, done_s, err_l, err_s;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  sarith_unit #(.W(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_l), .opa(a_l), .opb(b_l), .req(req_l),
    .result(res_l), .remainder(rem_l), .done(done_l), .err(err_l)
  );

  sarith_unit #(.W(WS)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_s), .opa(a_s), .opb(b_s), .req(req_s),
    .result(res_s), .remainder(rem_s), .done(done_s), .err(err_s)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input longint a, input longint b,
                                input int w, output longint r, output longint m,
                                output bit e);
    longint mx, mn, t;
    mx = (longint'(1) <<< (w - 1)) - 1;
    mn = -mx - 1;
    t = 0; m = 0; e = 1'b0;
    case (op)
      3'd1: t = a + b;
      3'd2: t = a - b;
      3'd3: t = a * b;
      3'd4: begin
        if (b == 0 || (a == mn && b == -1)) e = 1'b1;
        else begin
          t = a / b;
          m = a % b;
          if (m < 0) m = -m;
        end
      end
      default: t = 0;
    endcase
    if (op >= 3'd1 && op <= 3'd3 && (t > mx || t < mn)) e = 1'b1;
    if (e) begin t = 0; m = 0; end
    r = t;
  endfunction

  function automatic bit get_done(input bit sml);
    return sml ? done_s : done_l;
  endfunction

  task automatic drive(input bit sml, input logic [2:0] op, input longint a, input longint b,
                       input logic rq);
    if (sml) begin op_s = op; a_s = a[WS-1:0]; b_s = b[WS-1:0]; req_s = rq; end
    else     begin op_l = op; a_l = a[WL-1:0]; b_l = b[WL-1:0]; req_l = rq; end
  endtask

  task automatic sample(input bit sml, output longint r, output longint m, output longint e);
    if (sml) begin
      r = longint'($signed(res_s)); m = longint'($signed(rem_s)); e = longint'(err_s);
    end else begin
      r = longint'($signed(res_l)); m = longint'($signed(rem_l)); e = longint'(err_l);
    end
  endtask

  task automatic do_op(input bit sml, input logic [2:0] op, input longint a, input longint b);
    int w, edges, exp_lat;
    longint er, em, gr, gm, ge, hr, hm, he;
    bit ee;
    string rt, et;
    w = sml ? WS : WL;
    model(op, a, b, w, er, em, ee);
    case (op)
      3'd1, 3'd2: begin rt = "R2 result"; et = "R2 error"; end
      3'd3:       begin rt = "R3 result"; et = "R3 error"; end
      3'd4:       begin rt = "R4 quotient"; et = "R6 error"; end
      default:    begin rt = "R1 result"; et = "R1 error"; end
    endcase
    exp_lat = (op == 3'd4 && !ee) ? w + 3 : 1;
    @(negedge clk);
    drive(sml, op, a, b, 1'b1);
    edges = 0;
    do begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end while (!get_done(sml) && edges < 100);
    sample(sml, gr, gm, ge);
    chk(rt, gr, er);
    chk((op == 3'd4) ? "R5 remainder" : "R1 remainder", gm, em);
    chk(et, ge, longint'(ee));
    chk("R11 latency", edges, exp_lat);
    // R8: operand and opcode changes while req stays high are ignored
    drive(sml, ~op, ~a, b + 1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    sample(sml, hr, hm, he);
    chk("R8 done held", longint'(get_done(sml)), 1);
    chk("R8 result held", hr, gr);
    chk("R8 remainder held", hm, gm);
    drive(sml, op, a, b, 1'b0);
    @(posedge clk);
    @(negedge clk);
    sample(sml, hr, hm, he);
    chk("R9 done cleared", longint'(get_done(sml)), 0);
    chk("R9 error cleared", he, 0);
    chk("R9 result kept", hr, gr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    longint r, m, e;
    drive(1'b0, 3'd0, 0, 0, 1'b0);
    drive(1'b1, 3'd0, 0, 0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    sample(1'b0, r, m, e);
    chk("R10 reset result", r, 0);
    chk("R10 reset remainder", m, 0);
    chk("R10 reset error", e, 0);
    chk("R10 reset done", longint'(done_l), 0);
    rst_n = 1'b1;

    // R2 add/sub boundaries
    do_op(1'b0, 3'd1, 7, 3);
    do_op(1'b0, 3'd1, MAXV, 1);
    do_op(1'b0, 3'd1, MAXV, -1);
    do_op(1'b0, 3'd1, -2147483645, -100);
    do_op(1'b0, 3'd1, -2147483647, -1);
    do_op(1'b0, 3'd2, -2147483647, 1);
    do_op(1'b0, 3'd2, 5, MINV);
    do_op(1'b0, 3'd2, -1000, 2147483645);
    do_op(1'b0, 3'd2, 1000, -2147483645);
    do_op(1'b0, 3'd2, -1, MINV);
    // R3 multiply
    do_op(1'b0, 3'd3, -7, 3);
    do_op(1'b0, 3'd3, 90000, 100000);
    do_op(1'b0, 3'd3, -90000, 100000);
    do_op(1'b0, 3'd3, -90000, -100000);
    do_op(1'b0, 3'd3, -65536, 32768);
    do_op(1'b0, 3'd3, 65536, 32768);
    do_op(1'b0, 3'd3, MINV, -1);
    do_op(1'b0, 3'd3, 268435456, 32);
    // R4 R5 R6 divide
    do_op(1'b0, 3'd4, -5, 3);
    do_op(1'b0, 3'd4, 153156, 3543);
    do_op(1'b0, 3'd4, -153156, 3543);
    do_op(1'b0, 3'd4, 153156, -3543);
    do_op(1'b0, 3'd4, -153156, -3543);
    do_op(1'b0, 3'd4, MINV, 10);
    do_op(1'b0, 3'd4, MINV, -1);
    do_op(1'b0, 3'd4, MINV, 0);
    do_op(1'b0, 3'd4, 1, MINV);
    do_op(1'b0, 3'd4, 7, 10);
    do_op(1'b0, 3'd4, 5134123, 358015);
    do_op(1'b0, 3'd4, MINV, 1);
    do_op(1'b0, 3'd4, MINV, MINV);
    do_op(1'b0, 3'd4, MAXV, MINV);
    // R1 no-op and unused codes after a nonzero result
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c >= 5) begin
        do_op(1'b0, 3'd1, 11, 22);
        do_op(1'b0, c[2:0], 123, 456);
      end
    end

    // R10 reset in the middle of a divide
    do_op(1'b0, 3'd4, 7, 3);
    @(negedge clk);
    drive(1'b0, 3'd4, MAXV, 3, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    req_l = 1'b0;
    @(posedge clk);
    @(negedge clk);
    sample(1'b0, r, m, e);
    chk("R10 mid-op result", r, 0);
    chk("R10 mid-op remainder", m, 0);
    chk("R10 mid-op done", longint'(done_l), 0);
    repeat (WL + 5) @(posedge clk);
    @(negedge clk);
    chk("R10 no late done", longint'(done_l), 0);
    rst_n = 1'b1;
    do_op(1'b0, 3'd4, -2147483647, 7);

    // Full sweep on the narrow instance: R2 R3 R4 R5 R6 R7 R11
    for (int op = 1; op <= 4; op++)
      for (int a = -16; a < 16; a++)
        for (int b = -16; b < 16; b++)
          do_op(1'b1, op[2:0], longint'(a), longint'(b));
    for (int c = 0; c < 8; c++)
      if (c == 0 || c >= 5) do_op(1'b1, c[2:0], 9, -4);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule